// File: doc/BRIEF.md
# Interrupt-Driven Transfer Controller

This block sits between a set of interrupt request lines and a simple memory bus. Each of its eight channels owns a source pointer, a destination pointer, a transfer counter, a size bit and a bit that picks which pointer advances. A request on a channel is normally answered with a single move of one byte or one 16-bit word from the source address to the destination address. The move takes one bus read and one bus write, and the processor takes no part in it. After each move the selected pointer advances and the counter counts down. Once the counter stands at zero, the next request on that channel causes no move. The channel instead raises a one-cycle interrupt toward the processor's interrupt logic. A counter value of all ones marks continuous mode: the channel moves data on every request and never forwards one.

A configuration strobe loads all channel fields at once. The sequencer uses four named states. IDLE waits for a pending request. From IDLE, the GRANT_MOVE transition goes to READ and the GRANT_FWD transition goes to FORWARD; both transitions take the lowest-numbered pending channel and clear its pending flag. READ holds a bus read at the source until acknowledge, and the READ_DONE transition captures the data and goes to WRITE. WRITE holds a bus write of that data at the destination until acknowledge. Its WRITE_DONE transition steps the channel and returns to IDLE. FORWARD drives the interrupt for one cycle, and the FWD_DONE transition returns to IDLE.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: While reset is held and right after it, mem_req is 0 and every bit of irq_out is 0.
- R2: A serviced request performs one bus read at the source address followed by one bus write of the read data at the destination address. mem_word=1 moves all 16 bits. mem_word=0 moves the low 8 bits only, and the byte above the destination is left unchanged.
- R3: After each move, the destination pointer advances if the channel's increment select is 1, and the source pointer advances if it is 0. The step is 1 for byte channels and 2 for word channels. The other pointer keeps its value.
- R4: Each move decrements a non-continuous counter by one. A request that finds the counter at 0 makes no bus access and raises irq_out[channel] for exactly one cycle.
- R5: A channel loaded with count 0xFF (all ones) moves data on every request. Its counter never changes, and it never raises irq_out.
- R6: When several channels are pending, the lowest-numbered one is serviced first.
- R7: mem_req, mem_addr and mem_we hold steady from the rise of mem_req until mem_ack.
- R8: Requests are latched. A request that arrives while another service is in progress, including a new request on the channel being serviced, is serviced later and is not lost.
- R9: At most one bit of irq_out is high in any cycle, and irq_out never coincides with mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N_CH | Per-channel request pulses |
| cfg_we | input | 1 | Load strobe for one channel's fields |
| cfg_ch | input | IW | Channel index being loaded |
| cfg_src | input | AW | Source pointer value |
| cfg_dst | input | AW | Destination pointer value |
| cfg_cnt | input | CW | Transfer counter value (all ones = continuous) |
| cfg_word | input | 1 | 1 = word moves, 0 = byte moves |
| cfg_inc_dst | input | 1 | 1 = destination pointer steps, 0 = source pointer steps |
| mem_req | output | 1 | Bus request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Access size, 1 = 16-bit |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Bus acknowledge, one cycle |
| irq_out | output | N_CH | Forwarded interrupt pulses |

## Verification
The bench builds the block with eight channels, an 8-bit address and an 8-bit counter. The 8-bit address lets a 256-byte model cover the whole address space, so stray writes show up in memory contents. The 8-bit counter makes 0xFF the continuous code and lets short counts reach zero within a few requests. The bus model can insert a chosen number of wait cycles, so requests can be made to arrive in the middle of a move.

// File: rtl/etx_pkg.sv
package etx_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_READ = 2'd1,
        S_WRITE = 2'd2,
        S_FWD = 2'd3
    } etx_state_e;
endpackage

// File: rtl/etx_pend.sv
module etx_pend #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_in,
    input  logic [N-1:0]  clr,
    output logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] pick
);
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | req_in;
    end

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) pick = IW'(i);
        end
    end

    assign any = |pend;

    // R6: the chosen channel is pending and no lower channel is
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[pick] && ((pend & ((N'(1) << pick) - N'(1))) == '0)));

    // R8: a request pulse is always visible as pending on the next cycle
    p_req_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_in) |=> ((pend & $past(req_in)) == $past(req_in)));
endmodule

// File: rtl/etx_chan.sv
module etx_chan #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic          ld_word,
    input  logic          ld_incd,
    input  logic          step,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          word,
    output logic          incd
);
    localparam logic [CW-1:0] CONT = '1;

    logic [AW-1:0] amt;
    assign amt = word ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            word <= 1'b0;
            incd <= 1'b0;
        end else if (load) begin
            src  <= ld_src;
            dst  <= ld_dst;
            cnt  <= ld_cnt;
            word <= ld_word;
            incd <= ld_incd;
        end else if (step) begin
            if (incd) dst <= dst + amt;
            else      src <= src + amt;
            if (cnt != CONT && cnt != '0) cnt <= cnt - CW'(1);
        end
    end

    // R5: continuous channel keeps its count through a move
    p_cont_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt == CONT) |=> (cnt == CONT));

    // R3: only the selected pointer moves
    p_other_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !incd) |=> $stable(dst));
endmodule

// File: rtl/etx_seq.sv
module etx_seq
    import etx_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [IW-1:0]     pick,
    input  logic              pick_zero,
    input  logic [AW-1:0]     pick_src,
    input  logic [AW-1:0]     pick_dst,
    input  logic              pick_word,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [N-1:0]      clr,
    output logic [N-1:0]      step,
    output logic [N-1:0]      irq_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    etx_state_e    state, nxt;
    logic [IW-1:0] sel;
    logic [AW-1:0] xs, xd;
    logic          xw;
    logic [DATA_W-1:0] dat;

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (any) nxt = pick_zero ? S_FWD : S_READ;
            S_READ:  if (mem_ack) nxt = S_WRITE;
            S_WRITE: if (mem_ack) nxt = S_IDLE;
            S_FWD:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            sel   <= '0;
            xs    <= '0;
            xd    <= '0;
            xw    <= 1'b0;
            dat   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && any) begin
                sel <= pick;
                xs  <= pick_src;
                xd  <= pick_dst;
                xw  <= pick_word;
            end
            if (state == S_READ && mem_ack) dat <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        clr       = '0;
        step      = '0;
        irq_out   = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = xs;
        mem_word  = xw;
        mem_wdata = xw ? dat : {8'h00, dat[7:0]};
        unique case (state)
            S_IDLE:  if (any) clr = N'(1) << pick;
            S_READ:  mem_req = 1'b1;
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = xd;
                if (mem_ack) step = N'(1) << sel;
            end
            S_FWD:   irq_out = N'(1) << sel;
            default: ;
        endcase
    end

    // R7: bus request and its attributes hold until acknowledge
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: a write starts only right after an acknowledged read
    p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

    // R9: one forwarded interrupt at a time
    p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));

    // R4: forwarding uses no bus
    p_fwd_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> !mem_req);

    // R1: quiet outputs in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && irq_out == '0));
endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
    import etx_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 16,
    parameter int CW   = 8,
    localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   req_in,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_ch,
    input  logic [AW-1:0]     cfg_src,
    input  logic [AW-1:0]     cfg_dst,
    input  logic [CW-1:0]     cfg_cnt,
    input  logic              cfg_word,
    input  logic              cfg_inc_dst,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [N_CH-1:0]   irq_out
);
    logic [N_CH-1:0] pend, clr, step;
    logic            any;
    logic [IW-1:0]   pick;

    logic [AW-1:0] src_a [N_CH];
    logic [AW-1:0] dst_a [N_CH];
    logic [CW-1:0] cnt_a [N_CH];
    logic [N_CH-1:0] word_a, incd_a;

    etx_pend #(.N(N_CH), .IW(IW)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr(clr),
        .pend(pend), .any(any), .pick(pick)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        etx_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .load(cfg_we && (cfg_ch == IW'(g))),
            .ld_src(cfg_src), .ld_dst(cfg_dst), .ld_cnt(cfg_cnt),
            .ld_word(cfg_word), .ld_incd(cfg_inc_dst),
            .step(step[g]),
            .src(src_a[g]), .dst(dst_a[g]), .cnt(cnt_a[g]),
            .word(word_a[g]), .incd(incd_a[g])
        );
    end

    etx_seq #(.N(N_CH), .IW(IW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .any(any), .pick(pick),
        .pick_zero(cnt_a[pick] == '0),
        .pick_src(src_a[pick]), .pick_dst(dst_a[pick]), .pick_word(word_a[pick]),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .clr(clr), .step(step), .irq_out(irq_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: tb/tb_evt_xfer_ctrl.sv
module tb_evt_xfer_ctrl;
    localparam int CLK_P = 10;
    localparam int N = 8;
    localparam int AW = 8;
    localparam int CW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req_in = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_ch = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic cfg_word = 1'b0, cfg_inc_dst = 1'b0;
    logic mem_req, mem_we, mem_word;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic [N-1:0] irq_out;

    int total = 0, bad = 0;
    bit done = 1'b0;

    evt_xfer_ctrl #(.N_CH(N), .AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_cnt(cfg_cnt), .cfg_word(cfg_word), .cfg_inc_dst(cfg_inc_dst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq_out(irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // memory model with programmable wait cycles
    logic [7:0] mem [256];
    int wait_cfg = 0, dly = 0;
    int rd_count = 0, wr_count = 0;
    logic [AW-1:0] wr_log [64];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (dly >= wait_cfg) begin
                dly <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata[7:0];
                    if (mem_word) mem[mem_addr + 8'd1] <= mem_wdata[15:8];
                    if (wr_count < 64) wr_log[wr_count] <= mem_addr;
                    wr_count <= wr_count + 1;
                end else begin
                    mem_rdata <= {mem[mem_addr + 8'd1], mem[mem_addr]};
                    rd_count <= rd_count + 1;
                end
            end else begin
                dly <= dly + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // interrupt monitor
    int irq_seen [N];
    int irq_multi = 0, irq_bus = 0;
    initial for (int i = 0; i < N; i++) irq_seen[i] = 0;
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) if (irq_out[i]) irq_seen[i]++;
        if ($countones(irq_out) > 1) irq_multi++;
        if ((|irq_out) && mem_req) irq_bus++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int s, input int d, input int c,
                       input bit w, input bit incd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_src = AW'(s); cfg_dst = AW'(d);
        cfg_cnt = CW'(c); cfg_word = w; cfg_inc_dst = incd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] v);
        @(negedge clk);
        req_in = v;
        @(negedge clk);
        req_in = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
        chk(irq_out == '0, "R1 irq_out", int'(irq_out), 0);
    endtask

    task automatic t_byte_src;
        int w0;
        mem[8'h10] = 8'hA5; mem[8'h11] = 8'h5A; mem[8'h81] = 8'hEE;
        cfg(0, 8'h10, 8'h80, 2, 1'b0, 1'b0);
        pulse(8'h01); settle(20);
        chk(mem[8'h80] == 8'hA5, "R2 byte move", int'(mem[8'h80]), 'hA5);
        chk(mem[8'h81] == 8'hEE, "R2 byte upper untouched", int'(mem[8'h81]), 'hEE);
        pulse(8'h01); settle(20);
        chk(mem[8'h80] == 8'h5A, "R3 source stepped by 1", int'(mem[8'h80]), 'h5A);
        w0 = wr_count;
        pulse(8'h01); settle(20);
        chk(wr_count == w0, "R4 no move at zero", wr_count, w0);
        chk(irq_seen[0] == 1, "R4 forward pulse", irq_seen[0], 1);
    endtask

    task automatic t_word_dst;
        mem[8'h20] = 8'h34; mem[8'h21] = 8'h12;
        cfg(3, 8'h20, 8'h40, 5, 1'b1, 1'b1);
        pulse(8'h08); settle(20);
        pulse(8'h08); settle(20);
        chk({mem[8'h41], mem[8'h40]} == 16'h1234, "R2 word move", int'({mem[8'h41], mem[8'h40]}), 'h1234);
        chk({mem[8'h43], mem[8'h42]} == 16'h1234, "R3 destination stepped by 2",
            int'({mem[8'h43], mem[8'h42]}), 'h1234);
        chk(irq_seen[3] == 0, "R4 no forward before zero", irq_seen[3], 0);
    endtask

    task automatic t_cont;
        int w0;
        w0 = wr_count;
        mem[8'h30] = 8'h77;
        cfg(5, 8'h30, 8'hA0, 8'hFF, 1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            pulse(8'h20); settle(20);
        end
        chk(wr_count == w0 + 6, "R5 continuous moves", wr_count, w0 + 6);
        chk(mem[8'hA5] == 8'h77, "R5 sixth move", int'(mem[8'hA5]), 'h77);
        chk(irq_seen[5] == 0, "R5 never forwards", irq_seen[5], 0);
    endtask

    task automatic t_zero;
        int w0, r0;
        w0 = wr_count; r0 = rd_count;
        cfg(7, 8'h00, 8'hF0, 0, 1'b0, 1'b0);
        pulse(8'h80); settle(20);
        chk(irq_seen[7] == 1, "R4 zero count forwards", irq_seen[7], 1);
        chk(rd_count == r0 && wr_count == w0, "R4 zero count no bus", rd_count + wr_count, r0 + w0);
    endtask

    task automatic t_prio;
        int w0;
        w0 = wr_count;
        mem[8'h31] = 8'h66; mem[8'h32] = 8'h22;
        cfg(6, 8'h31, 8'hB0, 5, 1'b0, 1'b0);
        cfg(2, 8'h32, 8'hB8, 5, 1'b0, 1'b0);
        pulse(8'h44); settle(40);
        chk(wr_log[w0] == 8'hB8, "R6 lowest channel first", int'(wr_log[w0]), 'hB8);
        chk(mem[8'hB0] == 8'h66 && mem[8'hB8] == 8'h22, "R6 both serviced",
            int'({mem[8'hB0], mem[8'hB8]}), 'h6622);
    endtask

    task automatic t_latch;
        wait_cfg = 4;
        mem[8'h33] = 8'h99;
        cfg(1, 8'h33, 8'hC0, 10, 1'b0, 1'b1);
        cfg(4, 8'h00, 8'h00, 0, 1'b0, 1'b0);
        pulse(8'h02);
        settle(3);
        pulse(8'h12);
        settle(80);
        chk(mem[8'hC0] == 8'h99, "R7 move with wait cycles", int'(mem[8'hC0]), 'h99);
        chk(mem[8'hC1] == 8'h99, "R8 repeat request kept", int'(mem[8'hC1]), 'h99);
        chk(irq_seen[4] == 1, "R8 other channel kept", irq_seen[4], 1);
        wait_cfg = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_byte_src;
        t_word_dst;
        t_cont;
        t_zero;
        t_prio;
        t_latch;
        chk(irq_multi == 0, "R9 one irq at a time", irq_multi, 0);
        chk(irq_bus == 0, "R9 irq apart from bus", irq_bus, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule